// File: doc/BRIEF.md
# Time-Multiplexed Configurable FIR Filter

This block is a single-channel FIR filter for signed 16-bit samples that produces 32-bit results. Sixteen multiply-accumulate slices are reused one, two, four or eight times per sample period. Each reuse adds sixteen taps, so a slower input rate buys a longer filter. A decimate-by-two setting runs a window twice as long, which doubles the tap count at the same input rate and gives one result for every second sample.

The block sets its own sample timing. It raises `smp_take` in each cycle where it accepts the value on `smp_in`. Coefficients are loaded through a simple write port. A 3-bit mode code picks the setting, and writing the code restarts the sequencing.

For longer filters, several instances can be chained. `casc_out` passes on samples delayed by this stage's full tap span. A partial sum arriving on `casc_in` is added into each result. The result bus is high impedance unless a registered active-low enable allows it to be driven.

Top module: `tmux_fir`

## Requirements
- R1: `mode_code` selects passes P, decimation D, window Q=P*(1+D) and taps N=16*Q:
  - 000 gives P=1, D=0, 16 taps.
  - 001 gives P=1, D=1, 32 taps.
  - 010 gives P=2, D=0, 32 taps.
  - 011 gives P=2, D=1, 64 taps.
  - 100 gives P=4, D=0, 64 taps.
  - 101 gives P=4, D=1, 128 taps.
  - 110 gives P=8, D=0, 128 taps.
- R2: `smp_take` is high for one cycle in every P cycles, and the value on `smp_in` in such a cycle is accepted.
- R3: A result equals `casc_in` plus the sum over k<N of coef[k]*x[n-k]. Here x[n] is the newest sample of the window, samples before the last mode write or reset count as zero, and all terms are signed. Accumulation is exact and the sum is truncated to 32 bits, so it wraps on overflow.
- R4: With D=1, one result is produced per two accepted samples. The first, third and fifth samples after a restart, and so on, are the newest sample of their result.
- R5: With the newest sample of a result accepted in cycle c, `res_valid` is high and the result is on the bus in cycle c+L. L is 16, 17, 16, 18, 20, 24 and 24 for codes 000 to 110, and 24 for 111.
- R6: `res_valid` is high for exactly one cycle per result, and the bus value does not change between results.
- R7: In a cycle where `smp_take` is high, `casc_out` shows the sample accepted N takes earlier, or zero if no such sample exists since the restart. It changes only at takes.
- R8: The `casc_in` value present in the cycle before `res_valid` rises is the value added to that result.
- R9: `oe_n` is sampled on each rising edge. The bus is driven in the cycles after an edge that saw `oe_n` low and is high impedance otherwise.
- R10: Code 111 behaves exactly like code 110.
- R11: Writing value v to `coef_addr` k sets coef[k]=v, and coefficient 0 multiplies the newest sample.
- R12: A mode write or reset clears the history and any pending results, and `smp_take` is high in the following cycle. After reset the code is 000 and the held result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Writes `mode_code` and restarts sequencing |
| mode_code | input | 3 | Setting code |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Coefficient index |
| coef_wdata | input | 16 | Signed coefficient value |
| smp_in | input | 16 | Signed input sample |
| smp_take | output | 1 | High when `smp_in` is accepted this cycle |
| casc_in | input | 32 | Partial sum from a chained stage |
| casc_out | output | 16 | Samples delayed by this stage's tap span |
| oe_n | input | 1 | Result bus enable, active low, registered |
| res_bus | output | 32 | Filter result, tristate |
| res_valid | output | 1 | One-cycle pulse per new result |

## Verification
In every setting, each result is compared in value and in arrival cycle with a convolution computed in the bench. These checks catch the following faults:
- A latency padding that is off by one for one code shows up as a wrong arrival cycle.
- A decimate window that ignores the history shift in its middle gives a result built from taps offset by one sample.
- Reversed tap order is exposed by an impulse run, which must return the coefficients in address order.
- An accumulator that saturates, or that drops the products' upper bits, fails an all-minimum run whose exact sum wraps through zero.
- Treating the reserved code as anything other than 128 taps at one eighth rate gives the wrong spacing.
- Applying the enable combinationally makes the bus change one cycle early.

// File: rtl/tmux_fir.sv
`timescale 1ns/1ps
module tmux_fir #(
  parameter int DW   = 16,
  parameter int RW   = 32,
  parameter int MACS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_we,
  input  logic [2:0]                  mode_code,
  input  logic                        coef_we,
  input  logic [$clog2(MACS*8)-1:0]   coef_addr,
  input  logic [DW-1:0]               coef_wdata,
  input  logic [DW-1:0]               smp_in,
  output logic                        smp_take,
  input  logic [RW-1:0]               casc_in,
  output logic [DW-1:0]               casc_out,
  input  logic                        oe_n,
  output wire  [RW-1:0]               res_bus,
  output logic                        res_valid
);
  localparam int MAXPASS = 8;
  localparam int NTAP    = MACS * MAXPASS;
  localparam int AW      = $clog2(NTAP);
  localparam int HD      = NTAP + 1;
  localparam int HW      = $clog2(HD);
  localparam int ACCW    = 2 * DW + AW;
  localparam int DLN     = 16;
  localparam int DSW     = $clog2(DLN);

  logic [2:0]  code;
  logic [1:0]  pidx;
  logic        dec;
  logic [3:0]  nps, nq;
  logic [DSW-1:0] dsel;
  logic [HW-1:0]  tail;

  logic [2:0]  ph, pass;
  logic        dph, busy, start, ph_last, pass_last, shifted;
  logic        oe_q, res_v;
  logic [RW-1:0] res_q;
  logic signed [ACCW-1:0] acc, psum;
  logic signed [DW-1:0] hist [HD];
  logic signed [DW-1:0] coef [NTAP];
  logic [DLN-1:0] lv;
  logic [RW-1:0]  ld [DLN];

  function automatic logic [4:0] lat_of(input logic [2:0] c);
    case (c)
      3'd0:    return 5'd16;
      3'd1:    return 5'd17;
      3'd2:    return 5'd16;
      3'd3:    return 5'd18;
      3'd4:    return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

  assign pidx = code[2:1];
  assign dec  = code[0] & ~(code[2] & code[1]);
  assign nps  = 4'd1 << pidx;
  assign nq   = nps << dec;
  assign dsel = DSW'(lat_of(code) - 5'(nq) - 5'd2);
  assign tail = HW'(int'(nq) * MACS - 1);

  assign smp_take  = (ph == 3'd0) & ~mode_we;
  assign start     = smp_take & ~dph;
  assign ph_last   = ({1'b0, ph} == nps - 4'd1);
  assign pass_last = ({1'b0, pass} == nq - 4'd1);
  assign shifted   = dec & ({1'b0, pass} >= nps);

  assign casc_out  = hist[tail];
  assign res_valid = res_v;
  assign res_bus   = oe_q ? 'z : res_q;

  always_comb begin
    int ci;
    logic signed [2*DW-1:0] prod;
    psum = '0;
    for (int m = 0; m < MACS; m++) begin
      ci   = int'(pass) * MACS + m;
      prod = hist[HW'(ci + int'(shifted))] * coef[AW'(ci)];
      psum = psum + ACCW'(prod);
    end
  end

  always_ff @(posedge clk) oe_q <= oe_n;

  always_ff @(posedge clk) begin
    if (coef_we) coef[coef_addr] <= coef_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= 3'd0;
      ph    <= '0;
      dph   <= 1'b0;
      pass  <= '0;
      busy  <= 1'b0;
      acc   <= '0;
      lv    <= '0;
      res_v <= 1'b0;
      res_q <= '0;
      for (int i = 0; i < HD; i++) hist[i] <= '0;
    end else if (mode_we) begin
      code  <= mode_code;
      ph    <= '0;
      dph   <= 1'b0;
      pass  <= '0;
      busy  <= 1'b0;
      acc   <= '0;
      lv    <= '0;
      res_v <= 1'b0;
      for (int i = 0; i < HD; i++) hist[i] <= '0;
    end else begin
      ph <= ph_last ? 3'd0 : ph + 3'd1;
      if (smp_take) begin
        hist[0] <= smp_in;
        for (int i = 1; i < HD; i++) hist[i] <= hist[i-1];
        if (dec) dph <= ~dph;
      end
      lv <= {lv[DLN-2:0], 1'b0};
      for (int k = 1; k < DLN; k++) ld[k] <= ld[k-1];
      if (busy) begin
        if (pass_last) begin
          ld[0] <= RW'(acc + psum);
          lv[0] <= 1'b1;
          busy  <= 1'b0;
        end else begin
          acc  <= acc + psum;
          pass <= pass + 3'd1;
        end
      end
      if (start) begin
        busy <= 1'b1;
        pass <= '0;
        acc  <= '0;
      end
      res_v <= lv[dsel];
      if (lv[dsel]) res_q <= ld[dsel] + casc_in;
    end
  end
endmodule

module tmux_fir_chk #(
  parameter int DW = 16,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_we,
  input logic          smp_take,
  input logic          res_valid,
  input logic          oe_n,
  input logic          oe_q,
  input logic [2:0]    code,
  input logic [DW-1:0] casc_out,
  input logic [RW-1:0] res_q
);
  assert_take_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_take && !mode_we && code[2:1] != 2'b00) |=> !smp_take);

  assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (smp_take || mode_we));

  assert_res_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && code != 3'b000) |=> !res_valid);

  assert_res_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_q));

  assert_oe_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q == $past(oe_n));

  assert_tail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_take && !mode_we) |=> $stable(casc_out));
endmodule

bind tmux_fir tmux_fir_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .smp_take(smp_take),
  .res_valid(res_valid), .oe_n(oe_n), .oe_q(oe_q), .code(code),
  .casc_out(casc_out), .res_q(res_q)
);

// File: tb/test_tmux_fir.sv
`timescale 1ns/1ps
module test_tmux_fir;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [2:0]  mode_code = 3'd0;
  logic        coef_we = 1'b0;
  logic [6:0]  coef_addr = '0;
  logic [15:0] coef_wdata = '0;
  logic [15:0] smp_in = '0;
  logic        smp_take;
  logic [31:0] casc_in = '0;
  logic [15:0] casc_out;
  logic        oe_n = 1'b0;
  wire  [31:0] res_bus;
  logic        res_valid;

  always #4 clk = ~clk;

  for (genvar g = 0; g < 32; g++) begin : g_pu
    pullup (res_bus[g]);
  end

  tmux_fir i_tmux_fir (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_code(mode_code),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .smp_in(smp_in), .smp_take(smp_take), .casc_in(casc_in),
    .casc_out(casc_out), .oe_n(oe_n), .res_bus(res_bus), .res_valid(res_valid)
  );

  int nchk = 0, nfail = 0;
  int hb [128];
  logic signed [15:0] xs [300];
  int tk [300];
  logic [31:0] last_res = '0;

  function automatic int p_of(input logic [2:0] c);
    case (c[2:1])
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int d_of(input logic [2:0] c);
    return (c == 3'd1 || c == 3'd3 || c == 3'd5) ? 1 : 0;
  endfunction

  function automatic int l_of(input logic [2:0] c);
    case (c)
      3'd0: return 16;
      3'd1: return 17;
      3'd2: return 16;
      3'd3: return 18;
      3'd4: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic signed [15:0] gen(input int kind, input int j);
    logic [31:0] t;
    t = j * 40503 + 12345;
    case (kind)
      0: return t[23:8];
      1: return (j == 0) ? 16'sd1 : 16'sd0;
      default: return 16'sh8000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic write_coefs(input int kind);
    for (int k = 0; k < 128; k++) begin
      case (kind)
        0: hb[k] = (k == 3) ? 32767 : (k == 7) ? -32768 : ((k * 37 + 5) % 2001) - 1000;
        1: hb[k] = k + 1;
        default: hb[k] = -32768;
      endcase
      @(negedge clk);
      coef_we = 1'b1; coef_addr = 7'(k); coef_wdata = 16'(hb[k]);
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic test_reset_state;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(smp_take == 1'b1, "R12", "take after reset", smp_take, 1);
    chk(res_valid == 1'b0, "R12", "valid after reset", res_valid, 0);
    chk(res_bus == 32'h0, "R12", "result after reset", res_bus, 0);
    last_res = 32'h0;
  endtask

  task automatic run_mode(input logic [2:0] c, input int skind,
                          input logic [31:0] casc, input string tag);
    int P, D, N, L, nsmp, ncyc, j, nout, nexp;
    longint s;
    P = p_of(c); D = d_of(c); N = 16 * P * (1 + D); L = l_of(c);
    nsmp = N + 12; ncyc = nsmp * P + L + 8; j = 0; nout = 0;
    nexp = nsmp / (1 + D);
    casc_in = casc;
    @(negedge clk);
    mode_we = 1'b1; mode_code = c;
    @(negedge clk);
    mode_we = 1'b0;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      #1;
      if (smp_take && j < 300) begin
        if (j > 0) chk(cyc - tk[j-1] == P, "R2", "take spacing", cyc - tk[j-1], P);
        chk(casc_out == ((j >= N) ? xs[j-N] : 16'sd0), "R7", "delayed sample",
            casc_out, (j >= N) ? xs[j-N] : 16'sd0);
        xs[j] = gen(skind, j); tk[j] = cyc; smp_in = xs[j]; j++;
      end
      if (res_valid) begin
        int a;
        a = nout * (1 + D);
        if (a < j) begin
          s = longint'(casc);
          for (int k = 0; k < N; k++)
            if (a - k >= 0) s += longint'(hb[k]) * longint'(xs[a-k]);
          chk(res_bus == s[31:0], tag, "result value", res_bus, s[31:0]);
          chk(cyc == tk[a] + L, "R5", "result cycle", cyc, tk[a] + L);
        end
        nout++;
        last_res = res_bus;
      end else if (nout > 0) begin
        chk(res_bus == last_res, "R6", "held result", res_bus, last_res);
      end
      @(negedge clk);
    end
    chk(nout >= nexp, "R4", "result count", nout, nexp);
  endtask

  task automatic test_oe;
    logic [31:0] v;
    #1;
    v = res_bus;
    @(negedge clk);
    oe_n = 1'b1;
    #1;
    chk(res_bus == v, "R9", "bus before disable edge", res_bus, v);
    @(negedge clk); #1;
    chk(res_bus == 32'hFFFF_FFFF, "R9", "bus released", res_bus, 32'hFFFF_FFFF);
    oe_n = 1'b0;
    #1;
    chk(res_bus == 32'hFFFF_FFFF, "R9", "bus before enable edge", res_bus, 32'hFFFF_FFFF);
    @(negedge clk); #1;
    chk(res_bus == v, "R9", "bus driven again", res_bus, v);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL R2 watchdog: run did not end, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    test_reset_state();
    write_coefs(1);
    run_mode(3'b000, 1, 32'h0, "R11");
    write_coefs(0);
    run_mode(3'b000, 0, 32'h0, "R1");
    run_mode(3'b010, 0, 32'h0, "R1");
    run_mode(3'b100, 0, 32'h0, "R1");
    run_mode(3'b110, 0, 32'h0, "R1");
    run_mode(3'b001, 0, 32'h0, "R4");
    run_mode(3'b011, 0, 32'h1234_5678, "R8");
    run_mode(3'b101, 0, 32'h0, "R4");
    run_mode(3'b111, 0, 32'h0, "R10");
    test_oe();
    write_coefs(2);
    run_mode(3'b110, 2, 32'h0, "R3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule